// File: doc/BRIEF.md
# Cascadable Priority Encoder (8-to-3 stage, 16-to-4 pair)

This block turns a set of active-low request lines into an active-low binary index that names the highest-numbered line being asserted. Each stage looks after eight request lines. An active-low enable gates the stage. A stage reports two things: through a group flag, that it is the one driving the index, and through an enable output, that nothing above the lower stages is asserted, so enable passes on to them. Chaining stages this way lets only the most significant group that has any request drive the result.

The top level joins two stages into a sixteen-line encoder. The enable output of the upper stage drives the enable of the lower stage. The upper stage's group flag becomes the most significant index bit. The low index bits are the bitwise AND of the two stages' active-low codes. Because a stage that is not enabled holds its code at all ones, the AND passes the code of whichever stage is active. The whole path is combinational, and is used wherever a keypad-style or interrupt-style set of lines must be reduced to the number of its most important active line.

Top module: `cascadeEncoder16`

## Requirements
- R1: A request line counts as active when it is low. The index output is the bitwise complement of the binary number of the winning line, so line 0 alone active gives codeN = 4'b1111.
- R2: While enN is high, codeN, groupN and enOutN are all high whatever the request lines hold.
- R3: While enN is low and several request lines are low, codeN names the highest-numbered active line, and lower lines have no effect.
- R4: While enN is low and at least one request line is low, groupN is low and enOutN is high.
- R5: While enN is low and no request line is low, enOutN is low, groupN is high and codeN is 4'b1111.
- R6: When any of lines 8 to 15 is active, the lower stage is disabled through the chained enable, and lines 0 to 7 have no effect on any output.
- R7: While enN is low, codeN[3] is low exactly when at least one of lines 8 to 15 is active.
- R8: While enN is low, codeN[2:0] is the complement of the low three bits of the winning line's number. This holds whether the winner lies in lines 0 to 7 or in lines 8 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enN | input | 1 | Active-low enable for the whole encoder |
| reqN | input | 16 | Active-low request lines, bit 15 has top priority |
| codeN | output | 4 | Active-low index of the highest active line |
| groupN | output | 1 | Low when this encoder has an active line while enabled |
| enOutN | output | 1 | Low when enabled with no active line, to enable a lower encoder |

## Verification
The checks take the inputs only as two-state levels that have settled. Nothing is assumed about how many request lines are low, so every one-hot, multi-hot and all-idle pattern is legal. The stimulus changes the inputs only once per bench cycle and samples after they settle. It walks all 65536 request patterns with the enable asserted, and a large sweep with it deasserted, so each property sees both of its branches.

// File: rtl/prioEncPkg.sv
package prioEncPkg;

  // Strobes passed from a stage's control to its datapath and output pins.
  typedef struct packed {
    logic driveCode;  // stage is enabled and has an active line
    logic groupHit;   // drives the group flag (active high inside)
    logic passDown;   // enable travels on to the next lower stage
  } encStrobes_t;

endpackage

// File: rtl/encControl.sv
module encControl
  import prioEncPkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             enN,
  input  logic [LANES-1:0] reqN,
  output encStrobes_t      strobes,
  output logic             groupN,
  output logic             enOutN
);

  logic enabled;
  logic anyReq;

  always_comb begin
    enabled           = ~enN;
    anyReq            = ~(&reqN);
    strobes.driveCode = enabled & anyReq;
    strobes.groupHit  = enabled & anyReq;
    strobes.passDown  = enabled & ~anyReq;
  end

  always_comb begin
    groupN = ~strobes.groupHit;
    enOutN = ~strobes.passDown;
  end

endmodule

// File: rtl/encDatapath.sv
module encDatapath
  import prioEncPkg::*;
#(
  parameter int LANES  = 8,
  parameter int CODE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  reqN,
  input  encStrobes_t       strobes,
  output logic [CODE_W-1:0] codeN
);

  logic [CODE_W-1:0] topIdx;

  // Scan upward so the last active line seen, the highest, wins.
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!reqN[i]) topIdx = CODE_W'(i);
    end
  end

  always_comb begin
    codeN = strobes.driveCode ? ~topIdx : '1;
  end

endmodule

// File: rtl/prioEncoder8.sv
module prioEncoder8
  import prioEncPkg::*;
#(
  parameter int LANES  = 8,
  parameter int CODE_W = $clog2(LANES)
) (
  input  logic              enN,
  input  logic [LANES-1:0]  reqN,
  output logic [CODE_W-1:0] codeN,
  output logic              groupN,
  output logic              enOutN
);

  encStrobes_t strobes;

  encControl #(.LANES(LANES)) u_ctrl (
    .enN    (enN),
    .reqN   (reqN),
    .strobes(strobes),
    .groupN (groupN),
    .enOutN (enOutN)
  );

  encDatapath #(.LANES(LANES), .CODE_W(CODE_W)) u_dp (
    .reqN   (reqN),
    .strobes(strobes),
    .codeN  (codeN)
  );

endmodule

// File: rtl/cascadeEncoder16.sv
module cascadeEncoder16 #(
  parameter int LANES  = 8,
  localparam int CODE_W = $clog2(LANES),
  localparam int TOTAL  = 2 * LANES,
  localparam int OUT_W  = CODE_W + 1
) (
  input  logic             enN,
  input  logic [TOTAL-1:0] reqN,
  output logic [OUT_W-1:0] codeN,
  output logic             groupN,
  output logic             enOutN
);

  logic [CODE_W-1:0] upperCode, lowerCode;
  logic              upperGroup, lowerGroup;
  logic              chainEn;
  logic              lowerEnOut;

  prioEncoder8 #(.LANES(LANES)) u_upper (
    .enN   (enN),
    .reqN  (reqN[TOTAL-1:LANES]),
    .codeN (upperCode),
    .groupN(upperGroup),
    .enOutN(chainEn)
  );

  prioEncoder8 #(.LANES(LANES)) u_lower (
    .enN   (chainEn),
    .reqN  (reqN[LANES-1:0]),
    .codeN (lowerCode),
    .groupN(lowerGroup),
    .enOutN(lowerEnOut)
  );

  always_comb begin
    codeN  = {upperGroup, upperCode & lowerCode};
    groupN = upperGroup & lowerGroup;
    enOutN = lowerEnOut;
  end

endmodule

// File: rtl/cascadeEncoder16Checker.sv
module cascadeEncoder16Checker #(
  parameter int TOTAL = 16,
  parameter int OUT_W = 4,
  parameter int LANES = 8
) (
  input logic             enN,
  input logic [TOTAL-1:0] reqN,
  input logic [OUT_W-1:0] codeN,
  input logic             groupN,
  input logic             enOutN
);

  always_comb begin
    if (enN) begin
      a_r2_disabled_idle: assert (&codeN && groupN && enOutN)
        else $error("R2 disabled encoder drives an output");
    end
    if (!enN && (&reqN)) begin
      a_r5_pass_down: assert (!enOutN && groupN && (&codeN))
        else $error("R5 idle enabled encoder misbehaves");
    end
    if (!enN) begin
      a_r4_one_flag: assert (groupN != enOutN)
        else $error("R4 group and enable-out flags not exclusive");
      a_r7_upper_bit: assert (codeN[OUT_W-1] == (&reqN[TOTAL-1:LANES]))
        else $error("R7 top code bit wrong");
    end
    if (!enN && !reqN[TOTAL-1]) begin
      a_r3_top_line: assert (codeN == '0)
        else $error("R3 top line active but code not all zeros");
    end
  end

endmodule

bind cascadeEncoder16 cascadeEncoder16Checker #(
  .TOTAL(TOTAL), .OUT_W(OUT_W), .LANES(LANES)
) u_checker (
  .enN   (enN),
  .reqN  (reqN),
  .codeN (codeN),
  .groupN(groupN),
  .enOutN(enOutN)
);

// File: tb/cascadeEncoder16_bench.sv
module cascadeEncoder16_bench;

  localparam time CLK_HALF = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enN = 1'b1;
  logic [15:0] reqN = '1;
  logic [3:0]  codeN;
  logic        groupN;
  logic        enOutN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #CLK_HALF clk = ~clk;

  cascadeEncoder16 u_cascadeEncoder16 (
    .enN   (enN),
    .reqN  (reqN),
    .codeN (codeN),
    .groupN(groupN),
    .enOutN(enOutN)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (en=%0b req=%04h)", tag, act, exp, enN, reqN);
    end
  endtask

  // Drive on the falling edge, sample after the next rising edge.
  task automatic apply(input logic e, input logic [15:0] r);
    @(negedge clk);
    enN  = e;
    reqN = r;
    @(posedge clk);
    #2ns;
  endtask

  task automatic compareRef();
    int hi;
    int expCode, expGrp, expEo;
    hi = -1;
    for (int i = 15; i >= 0; i--) begin
      if (reqN[i] == 1'b0 && hi < 0) hi = i;
    end
    if (enN) begin
      check("R2 code", codeN, 15);
      check("R2 group", groupN, 1);
      check("R2 enOut", enOutN, 1);
    end else if (hi < 0) begin
      check("R5 code", codeN, 15);
      check("R5 group", groupN, 1);
      check("R5 enOut", enOutN, 0);
    end else begin
      expCode = (~hi) & 15;
      expGrp  = 0;
      expEo   = 1;
      check("R7 top bit", int'(codeN[3]), (expCode >> 3) & 1);
      check(hi >= 8 ? "R8/R3 low bits upper" : "R8/R3 low bits lower", int'(codeN[2:0]), expCode & 7);
      check("R4 group", groupN, expGrp);
      check("R4 enOut", enOutN, expEo);
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2ns;
    check("R2 reset code", codeN, 15);
    check("R2 reset group", groupN, 1);
    check("R2 reset enOut", enOutN, 1);
    rstN = 1'b1;

    // R1: single lowest line active.
    apply(1'b0, 16'hFFFE);
    check("R1 line0 code", codeN, 15);
    apply(1'b0, 16'hFFFD);
    check("R1 line1 code", codeN, 14);
    // R6: upper line 9 active masks every lower line.
    apply(1'b0, 16'hFD00);
    check("R6 code", codeN, 6);
    apply(1'b0, 16'hFDFF);
    check("R6 code lower idle", codeN, 6);
    check("R6 enOut", enOutN, 1);
    // R3: several active, highest wins.
    apply(1'b0, 16'hFF3F);
    check("R3 lines6,7", codeN, 8);

    for (int p = 0; p < 65536; p++) begin
      apply(1'b0, 16'(p));
      compareRef();
    end
    for (int p = 0; p < 65536; p += 13) begin
      apply(1'b1, 16'(p));
      compareRef();
    end
    apply(1'b1, 16'hFFFF);
    compareRef();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule